// File: doc/BRIEF.md
# Receive Byte-Strobe and Destination Address Filter

This block sits on the receive side of a 4-bit media-independent receive stream, clocked by the receive clock. It searches for the start-of-frame delimiter. From the first destination nibble onward it drives a byte-phase strobe that is high on the first nibble of every byte. An external address matcher can use that strobe to capture bytes in step with the stream.

While the strobe runs, the block collects the 48-bit destination address. It compares the address with a programmed station address and with the broadcast address, and a promiscuous control forces a pass. An external reject line is sampled during the destination field. When data-valid falls, the block merges the internal match with the external reject line and issues a single-cycle accept or reject pulse.

Frames that show a receive error before the delimiter are dropped silently. Frames that end before the destination is complete are rejected.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `byte_strobe_o`, `frame_accept_o` and `frame_reject_o` are all low.
- R2: A frame starts only when a nibble 0x5 is followed directly by nibble 0xD, both sampled with `rx_dv_i` high and `rx_er_i` low. Any other sequence, such as 0x3 then 0xD, starts no frame, so no strobe and no decision follow.
- R3: `byte_strobe_o` is high in the cycle right after the edge that sampled the 0xD delimiter nibble. That is the cycle in which destination nibble 0 is on `rxd_i`.
- R4: While the frame continues with `rx_dv_i` high, `byte_strobe_o` toggles every cycle. It is high on even nibble indices (0, 2, 4, ...) counted from the first destination nibble.
- R5: `byte_strobe_o` is low whenever `rx_dv_i` is low, and low outside frame reception, including during the preamble.
- R6: Destination nibble k, counted from 0 after the delimiter, is stored at address bits [4k+3:4k]. Byte b therefore occupies bits [8b+7:8b], with its low nibble received first. The internal match passes when the 48-bit destination equals `station_addr_i`.
- R7: A destination of all ones (broadcast) passes the internal match.
- R8: With `promisc_i` high, the internal match passes for any destination.
- R9: `ext_reject_i` is sampled on the edges that capture destination nibbles 0 to 11. A high sample on any of them rejects the frame. Samples after the destination field have no effect.
- R10: The decision is a pulse of exactly one cycle, in the cycle after the edge that first samples `rx_dv_i` low in a frame. Exactly one of `frame_accept_o` and `frame_reject_o` is high in that pulse. Accept means the internal match passed and no external reject was sampled.
- R11: If `rx_er_i` is high on any nibble before the delimiter, the frame is dropped: no strobe and no decision until `rx_dv_i` falls.
- R12: If `rx_dv_i` falls before all 12 destination nibbles have arrived, the decision is a reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | NIB_W | Receive nibble |
| rx_dv_i | input | 1 | Receive data valid |
| rx_er_i | input | 1 | Receive error |
| ext_reject_i | input | 1 | External reject, active high |
| station_addr_i | input | ADDR_W | Programmed station address, byte 0 in bits [7:0] |
| promisc_i | input | 1 | Forces the internal match to pass |
| byte_strobe_o | output | 1 | High on the first nibble of each byte |
| frame_accept_o | output | 1 | One-cycle accept pulse at frame end |
| frame_reject_o | output | 1 | One-cycle reject pulse at frame end |

## Verification
The bench builds the block with its default parameters: a 48-bit address carried in 4-bit nibbles, so the destination spans 12 nibbles. Frames of 0, 5, 12 and 20 data nibbles therefore reach the aborted-destination path, the exact-length path and a frame carrying payload after the address. External reject pulses are placed on the first and last destination nibbles and on the first payload nibble. These show where the sampling window opens and closes.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_DROP} rx_state_e;
  localparam logic [3:0] PRE_NIB = 4'h5;
  localparam logic [3:0] SFD_NIB = 4'hD;
endpackage

// File: rtl/rx_sfd_fsm.sv
module rx_sfd_fsm
  import rx_filt_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic             rx_er_i,
  input  logic [NIB_W-1:0] rxd_i,
  output logic             sfd_hit_o,
  output logic             in_data_o,
  output logic             frame_end_o
);
  rx_state_e state_q;
  logic      prev_pre_q;

  always_comb begin
    sfd_hit_o   = (state_q == ST_IDLE || state_q == ST_PRE) && rx_dv_i && !rx_er_i &&
                  prev_pre_q && (rxd_i == NIB_W'(SFD_NIB));
    in_data_o   = (state_q == ST_DATA);
    frame_end_o = (state_q == ST_DATA) && !rx_dv_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      prev_pre_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE, ST_PRE: begin
          prev_pre_q <= 1'b0;
          if (!rx_dv_i)       state_q <= ST_IDLE;
          else if (rx_er_i)   state_q <= ST_DROP;
          else if (sfd_hit_o) state_q <= ST_DATA;
          else begin
            state_q    <= ST_PRE;
            prev_pre_q <= (rxd_i == NIB_W'(PRE_NIB));
          end
        end
        ST_DATA, ST_DROP: begin
          prev_pre_q <= 1'b0;
          if (!rx_dv_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  sfd_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_hit_o |=> in_data_o);

  // R11
  drop_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DROP) |=> !in_data_o);
endmodule

// File: rtl/rx_byte_strobe.sv
module rx_byte_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sfd_hit_i,
  input  logic in_data_i,
  input  logic rx_dv_i,
  output logic strobe_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    phase_q <= 1'b0;
    else if (sfd_hit_i)             phase_q <= 1'b1;
    else if (in_data_i && rx_dv_i)  phase_q <= ~phase_q;
    else                            phase_q <= 1'b0;
  end

  assign strobe_o = phase_q && in_data_i && rx_dv_i;

  // R3
  strobe_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfd_hit_i |=> (strobe_o || !rx_dv_i));

  // R4
  strobe_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/rx_dest_match.sv
module rx_dest_match #(
  parameter int ADDR_W = 48,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfd_hit_i,
  input  logic              in_data_i,
  input  logic              frame_end_i,
  input  logic              rx_dv_i,
  input  logic [NIB_W-1:0]  rxd_i,
  input  logic              ext_reject_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              promisc_i,
  output logic              accept_o,
  output logic              reject_o
);
  localparam int NIBS  = ADDR_W / NIB_W;
  localparam int CNT_W = $clog2(NIBS + 1);

  logic [CNT_W-1:0]            cnt_q;
  logic [NIBS-1:0][NIB_W-1:0]  dest_q;
  logic [ADDR_W-1:0]           dest_flat;
  logic                        xrej_q, done, capture, hit, pass;

  assign dest_flat = dest_q;
  assign done      = (cnt_q == CNT_W'(NIBS));
  assign capture   = in_data_i && rx_dv_i && !done;
  assign hit       = promisc_i || (dest_flat == station_addr_i) || (&dest_flat);
  assign pass      = done && hit && !xrej_q;

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              dest_q[g] <= '0;
      else if (sfd_hit_i)                       dest_q[g] <= '0;
      else if (capture && cnt_q == CNT_W'(g))   dest_q[g] <= rxd_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      xrej_q <= 1'b0;
    end else if (sfd_hit_i) begin
      cnt_q  <= '0;
      xrej_q <= 1'b0;
    end else if (capture) begin
      cnt_q  <= cnt_q + 1'b1;
      xrej_q <= xrej_q || ext_reject_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      accept_o <= frame_end_i && pass;
      reject_o <= frame_end_i && !pass;
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(NIBS));

  // R10
  one_decision_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept_o, reject_o}));

  // R10
  decision_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o || reject_o) |=> !(accept_o || reject_o));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_W = 48,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIB_W-1:0]  rxd_i,
  input  logic              rx_dv_i,
  input  logic              rx_er_i,
  input  logic              ext_reject_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic              promisc_i,
  output logic              byte_strobe_o,
  output logic              frame_accept_o,
  output logic              frame_reject_o
);
  logic sfd_hit, in_data, frame_end;

  rx_sfd_fsm #(.NIB_W(NIB_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_dv_i     (rx_dv_i),
    .rx_er_i     (rx_er_i),
    .rxd_i       (rxd_i),
    .sfd_hit_o   (sfd_hit),
    .in_data_o   (in_data),
    .frame_end_o (frame_end)
  );

  rx_byte_strobe u_strobe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sfd_hit_i (sfd_hit),
    .in_data_i (in_data),
    .rx_dv_i   (rx_dv_i),
    .strobe_o  (byte_strobe_o)
  );

  rx_dest_match #(.ADDR_W(ADDR_W), .NIB_W(NIB_W)) u_match (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sfd_hit_i      (sfd_hit),
    .in_data_i      (in_data),
    .frame_end_i    (frame_end),
    .rx_dv_i        (rx_dv_i),
    .rxd_i          (rxd_i),
    .ext_reject_i   (ext_reject_i),
    .station_addr_i (station_addr_i),
    .promisc_i      (promisc_i),
    .accept_o       (frame_accept_o),
    .reject_o       (frame_reject_o)
  );

  // R5
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_dv_i |-> !byte_strobe_o);

  // R10
  decision_after_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_accept_o || frame_reject_o) |-> !$past(rx_dv_i));
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  rxd;
  logic        rx_dv, rx_er, ext_rej, promisc;
  logic [47:0] station;
  logic        strobe, acc, rej;
  int          n_chk = 0, n_bad = 0;
  bit          done_flag = 0;

  always #10 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk_i (clk), .rst_ni (rst_n), .rxd_i (rxd), .rx_dv_i (rx_dv), .rx_er_i (rx_er),
    .ext_reject_i (ext_rej), .station_addr_i (station), .promisc_i (promisc),
    .byte_strobe_o (strobe), .frame_accept_o (acc), .frame_reject_o (rej)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic drive(input bit dv, input bit er, input logic [3:0] d, input bit x);
    @(negedge clk);
    rx_dv = dv; rx_er = er; rxd = d; ext_rej = x;
    #1;
  endtask

  function automatic int decode();
    return (acc && rej) ? 3 : acc ? 1 : rej ? 2 : 0;
  endfunction

  function automatic int expect_dec(input logic [47:0] dest, input int n_data,
                                    input int ext_at, input bit er_pre);
    bit m;
    if (er_pre) return 0;
    if (n_data < 12) return 2;
    m = promisc || (dest == station) || (&dest);
    return (m && !(ext_at >= 0 && ext_at < 12)) ? 1 : 2;
  endfunction

  task automatic run_frame(input logic [47:0] dest, input int n_data, input int ext_at,
                           input bit er_pre, input string tag);
    int sb_err = 0, busy_err = 0, exp_dec;
    exp_dec = expect_dec(dest, n_data, ext_at, er_pre);
    for (int i = 0; i < 6; i++) begin
      drive(1, er_pre && i == 2, 4'h5, 0);
      if (strobe) sb_err++;
    end
    drive(1, 0, 4'hD, 0);
    if (strobe) sb_err++;
    for (int k = 0; k < n_data; k++) begin
      logic [3:0] d;
      bit e;
      d = (k < 12) ? dest[4*k +: 4] : 4'hA;
      drive(1, 0, d, k == ext_at);
      e = !er_pre && (k % 2 == 0);
      if (strobe != e) sb_err++;
      if (acc || rej) busy_err++;
    end
    drive(0, 0, 4'h0, 0);
    if (strobe) sb_err++;
    if (acc || rej) busy_err++;
    chk(sb_err == 0, "R3 R4 R5", {tag, " strobe pattern errors"}, sb_err, 0);
    chk(busy_err == 0, "R10", {tag, " no decision inside frame"}, busy_err, 0);
    drive(0, 0, 4'h0, 0);
    chk(decode() == exp_dec, tag, "decision code", decode(), exp_dec);
    drive(0, 0, 4'h0, 0);
    chk(decode() == 0, "R10", {tag, " pulse lasts one cycle"}, decode(), 0);
  endtask

  task automatic t_reset();
    chk(!strobe && !acc && !rej, "R1", "outputs after reset", {strobe, acc, rej}, 0);
  endtask

  task automatic t_unicast();
    run_frame(station, 20, -1, 0, "R6 match");
    run_frame(station ^ 48'h0000_0000_0010, 12, -1, 0, "R6 miss nibble1");
    run_frame(station ^ 48'h8000_0000_0000, 14, -1, 0, "R6 miss last nibble");
  endtask

  task automatic t_broadcast();
    run_frame(48'hFFFF_FFFF_FFFF, 16, -1, 0, "R7 broadcast");
  endtask

  task automatic t_promisc();
    promisc = 1;
    run_frame(48'h1234_5678_9ABC, 16, -1, 0, "R8 promisc");
    promisc = 0;
    run_frame(48'h1234_5678_9ABC, 16, -1, 0, "R8 promisc off");
  endtask

  task automatic t_ext();
    run_frame(station, 16, 0, 0, "R9 ext nibble0");
    run_frame(station, 16, 11, 0, "R9 ext nibble11");
    run_frame(station, 16, 12, 0, "R9 ext after dest");
    run_frame(48'hFFFF_FFFF_FFFF, 16, 5, 0, "R9 ext broadcast");
  endtask

  task automatic t_short();
    run_frame(station, 5, -1, 0, "R12 short");
    run_frame(station, 0, -1, 0, "R12 empty");
  endtask

  task automatic t_err_pre();
    run_frame(station, 16, -1, 1, "R11 error in preamble");
  endtask

  task automatic t_bad_sfd();
    logic [3:0] seq [8] = '{4'h5, 4'h5, 4'h3, 4'hD, 4'h1, 4'h2, 4'hD, 4'h0};
    int hits = 0;
    foreach (seq[i]) begin
      drive(1, 0, seq[i], 0);
      if (strobe || acc || rej) hits++;
    end
    for (int i = 0; i < 3; i++) begin
      drive(0, 0, 4'h0, 0);
      if (strobe || acc || rej) hits++;
    end
    chk(hits == 0, "R2", "no frame without 5 then D", hits, 0);
    run_frame(station, 12, -1, 0, "R2 valid after bad");
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    rst_n = 0; rx_dv = 0; rx_er = 0; rxd = 0; ext_rej = 0; promisc = 0;
    station = 48'hC3A5_1E0F_7B26;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_unicast();
    t_broadcast();
    t_promisc();
    t_ext();
    t_short();
    t_err_pre();
    t_bad_sfd();
    done_flag = 1;
    finish_up();
  end
endmodule